// File: doc/BRIEF.md
# Boolean Logic Status Unit

This unit is the bit-logic core of a statement-list style controller processor. Each cycle it may accept one boolean instruction: an opcode and the present value of the bit that instruction addresses. It keeps four status bits (first-check, result-of-logic, status and OR-pending) and uses them to evaluate chains of AND and OR terms. AND terms bind more tightly than OR terms. For the assign, set and reset instructions it issues a write-enable and a write value toward an external bit memory. Instruction fetch, address decoding and the bit memory itself lie outside the unit.

The first-check bit is held by a two-state chain machine. In state `ST_FRESH` (first-check = 0) the next logic instruction opens a new chain: it loads its operand directly and clears the OR-pending bit. The transition `FRESH->CHAIN` fires on any logic instruction and leads to state `ST_CHAIN` (first-check = 1), where logic instructions combine with the running result. The transition `CHAIN->FRESH` fires on assign, set or reset. Every other case holds the state: `FRESH->FRESH` on a write or no instruction, and `CHAIN->CHAIN` on a logic instruction or no instruction. Inside a chain, an OR instruction folds the finished AND group into the OR-pending bit and starts a new group. The visible result-of-logic is the OR-pending bit ORed with the current group.

Top module: `bls_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all status bits, `wr_en` and `wr_val`, so `status_word` reads 0.
- R2: `status_word` packs first-check at bit 0, result-of-logic at bit 1, status at bit 2 and OR-pending at bit 3. Bits 4 to 15 always read 0.
- R3: Opcodes are 0 AND, 1 AND-NOT, 2 OR, 3 OR-NOT, 4 assign, 5 set, 6 reset and 7 no-operation. A logic opcode (0 to 3) taken while first-check is 0 loads its operand into result-of-logic, and clears OR-pending. The operand is inverted for opcodes 1 and 3.
- R4: Any logic opcode sets first-check to 1. Assign, set and reset clear it to 0.
- R5: An AND or AND-NOT taken while first-check is 1 ANDs its operand into the current group. Result-of-logic becomes OR-pending OR the new group.
- R6: An OR or OR-NOT taken while first-check is 1 first sets OR-pending to OR-pending OR the previous group. It then starts a new group equal to its operand, and result-of-logic becomes the new OR-pending OR that operand.
- R7: Every logic opcode loads the status bit with the raw, uninverted value of `bit_value`.
- R8: Assign raises `wr_en` with `wr_val` equal to result-of-logic. Assign, set and reset all clear OR-pending and leave result-of-logic and status unchanged.
- R9: Set raises `wr_en` with `wr_val` = 1, and reset raises `wr_en` with `wr_val` = 0, but only when result-of-logic is 1. Otherwise `wr_en` stays 0.
- R10: With `instr_valid` low, or with opcode 7, no status bit changes and `wr_en` is 0.
- R11: All effects of an instruction accepted at a rising edge are visible on the outputs right after that edge, and `wr_en` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction strobe; one instruction is accepted per cycle while high |
| instr_op | input | 3 | Opcode, encoded as in R3 |
| bit_value | input | 1 | Current value of the addressed bit |
| wr_en | output | 1 | Bit-memory write enable, one cycle per write |
| wr_val | output | 1 | Value to write into the addressed bit |
| status_word | output | 16 | Packed status bits, laid out as in R2 |

## Verification
Every result is registered once. All status bits, `wr_en` and `wr_val` change at the rising edge that accepts the instruction and are due one cycle after the strobe. The bench drives each instruction on a falling edge and lets one rising edge pass. At the next falling edge it compares every output bit with a behavioural model that was advanced by the same instruction. Because of this, a delayed, early or stretched write pulse shows up as a mismatch at a known cycle. Directed chains cover mixed AND/OR grouping, negated operands, gaps in the strobe, no-operations and conditional set/reset. A long pseudo-random stream follows them.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [2:0] {
        OP_AND    = 3'd0,
        OP_ANDN   = 3'd1,
        OP_OR     = 3'd2,
        OP_ORN    = 3'd3,
        OP_ASSIGN = 3'd4,
        OP_SET    = 3'd5,
        OP_RESET  = 3'd6,
        OP_NOP    = 3'd7
    } bls_op_e;

    typedef enum logic {
        ST_FRESH = 1'b0,
        ST_CHAIN = 1'b1
    } bls_chain_e;

    typedef struct packed {
        logic logic_op;
        logic or_op;
        logic negate;
        logic wr_assign;
        logic wr_set;
        logic wr_reset;
    } bls_dec_t;

    localparam int unsigned FLAG_BITS = 4;

endpackage

// File: rtl/bls_decode.sv
module bls_decode
    import bls_pkg::*;
(
    input  logic       valid_i,
    input  logic [2:0] op_i,
    output bls_dec_t   dec_o
);

    always_comb begin
        dec_o = '0;
        if (valid_i) begin
            unique case (bls_op_e'(op_i))
                OP_AND: begin
                    dec_o.logic_op = 1'b1;
                end
                OP_ANDN: begin
                    dec_o.logic_op = 1'b1;
                    dec_o.negate   = 1'b1;
                end
                OP_OR: begin
                    dec_o.logic_op = 1'b1;
                    dec_o.or_op    = 1'b1;
                end
                OP_ORN: begin
                    dec_o.logic_op = 1'b1;
                    dec_o.or_op    = 1'b1;
                    dec_o.negate   = 1'b1;
                end
                OP_ASSIGN: dec_o.wr_assign = 1'b1;
                OP_SET:    dec_o.wr_set    = 1'b1;
                OP_RESET:  dec_o.wr_reset  = 1'b1;
                OP_NOP:    dec_o = '0;
            endcase
        end
    end

    // decoded classes never overlap
    always_comb begin
        assert_dec_exclusive_R3: assert ($onehot0({dec_o.logic_op, dec_o.wr_assign,
                                                   dec_o.wr_set, dec_o.wr_reset}));
    end

endmodule

// File: rtl/bls_chain_fsm.sv
module bls_chain_fsm
    import bls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bls_dec_t dec_i,
    output logic     first_check_o
);

    bls_chain_e state_q, state_d;
    logic       any_write;

    assign any_write = dec_i.wr_assign | dec_i.wr_set | dec_i.wr_reset;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FRESH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FRESH: if (dec_i.logic_op) state_d = ST_CHAIN;
            ST_CHAIN: if (any_write)      state_d = ST_FRESH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FRESH: first_check_o = 1'b0;
            ST_CHAIN: first_check_o = 1'b1;
        endcase
    end

    assert_logic_opens_chain_R4: assert property (@(posedge clk) disable iff (rst)
        dec_i.logic_op |=> first_check_o);

    assert_write_closes_chain_R4: assert property (@(posedge clk) disable iff (rst)
        any_write |=> !first_check_o);

    assert_idle_holds_state_R10: assert property (@(posedge clk) disable iff (rst)
        (!dec_i.logic_op && !any_write) |=> $stable(first_check_o));

endmodule

// File: rtl/bls_accum.sv
module bls_accum
    import bls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bls_dec_t dec_i,
    input  logic     first_check_i,
    input  logic     bit_i,
    output logic     rlo_o,
    output logic     sta_o,
    output logic     or_o
);

    logic grp_q, or_q, sta_q, rlo_q;
    logic grp_d, or_d, sta_d, rlo_d;
    logic operand, any_write;

    assign operand   = bit_i ^ dec_i.negate;
    assign any_write = dec_i.wr_assign | dec_i.wr_set | dec_i.wr_reset;

    always_comb begin
        grp_d = grp_q;
        or_d  = or_q;
        sta_d = sta_q;
        rlo_d = rlo_q;
        if (dec_i.logic_op) begin
            sta_d = bit_i;
            if (!first_check_i) begin
                grp_d = operand;
                or_d  = 1'b0;
            end else if (dec_i.or_op) begin
                or_d  = or_q | grp_q;
                grp_d = operand;
            end else begin
                grp_d = grp_q & operand;
            end
            rlo_d = or_d | grp_d;
        end else if (any_write) begin
            or_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= 1'b0;
            or_q  <= 1'b0;
            sta_q <= 1'b0;
            rlo_q <= 1'b0;
        end else begin
            grp_q <= grp_d;
            or_q  <= or_d;
            sta_q <= sta_d;
            rlo_q <= rlo_d;
        end
    end

    assign rlo_o = rlo_q;
    assign sta_o = sta_q;
    assign or_o  = or_q;

    assert_chain_start_loads_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_i.logic_op && !first_check_i) |=> (rlo_o == ($past(bit_i) ^ $past(dec_i.negate))) && !or_o);

    assert_status_raw_bit_R7: assert property (@(posedge clk) disable iff (rst)
        dec_i.logic_op |=> sta_o == $past(bit_i));

    assert_write_keeps_rlo_R8: assert property (@(posedge clk) disable iff (rst)
        any_write |=> $stable(rlo_o) && $stable(sta_o) && !or_o);

    assert_and_never_raises_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_i.logic_op && first_check_i && !dec_i.or_op && !rlo_o) |=> !rlo_o);

endmodule

// File: rtl/bls_write.sv
module bls_write
    import bls_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bls_dec_t dec_i,
    input  logic     rlo_i,
    output logic     wr_en_o,
    output logic     wr_val_o
);

    logic en_d, val_d;

    always_comb begin
        en_d  = 1'b0;
        val_d = 1'b0;
        if (dec_i.wr_assign) begin
            en_d  = 1'b1;
            val_d = rlo_i;
        end else if (dec_i.wr_set) begin
            en_d  = rlo_i;
            val_d = 1'b1;
        end else if (dec_i.wr_reset) begin
            en_d  = rlo_i;
            val_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o  <= 1'b0;
            wr_val_o <= 1'b0;
        end else begin
            wr_en_o  <= en_d;
            wr_val_o <= val_d;
        end
    end

    assert_assign_copies_rlo_R8: assert property (@(posedge clk) disable iff (rst)
        dec_i.wr_assign |=> wr_en_o && (wr_val_o == $past(rlo_i)));

    assert_set_when_true_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_i.wr_set && rlo_i) |=> wr_en_o && wr_val_o);

    assert_clear_when_true_R9: assert property (@(posedge clk) disable iff (rst)
        (dec_i.wr_reset && rlo_i) |=> wr_en_o && !wr_val_o);

    assert_no_write_otherwise_R10: assert property (@(posedge clk) disable iff (rst)
        !(dec_i.wr_assign || ((dec_i.wr_set || dec_i.wr_reset) && rlo_i)) |=> !wr_en_o);

endmodule

// File: rtl/bls_top.sv
module bls_top
    import bls_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic              bit_value,
    output logic              wr_en,
    output logic              wr_val,
    output logic [WORD_W-1:0] status_word
);

    localparam int unsigned PAD_W = WORD_W - FLAG_BITS;

    bls_dec_t dec;
    logic     fc, rlo, sta, orb;

    bls_decode u_decode (
        .valid_i (instr_valid),
        .op_i    (instr_op),
        .dec_o   (dec)
    );

    bls_chain_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .dec_i         (dec),
        .first_check_o (fc)
    );

    bls_accum u_accum (
        .clk           (clk),
        .rst           (rst),
        .dec_i         (dec),
        .first_check_i (fc),
        .bit_i         (bit_value),
        .rlo_o         (rlo),
        .sta_o         (sta),
        .or_o          (orb)
    );

    bls_write u_write (
        .clk      (clk),
        .rst      (rst),
        .dec_i    (dec),
        .rlo_i    (rlo),
        .wr_en_o  (wr_en),
        .wr_val_o (wr_val)
    );

    assign status_word = {{PAD_W{1'b0}}, orb, sta, rlo, fc};

    assert_write_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(dec.wr_assign || dec.wr_set || dec.wr_reset)) |=> !wr_en);

endmodule

// File: tb/sim_bls_top.sv
`timescale 1ns/1ps
module sim_bls_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [2:0]  instr_op;
    logic        bit_value;
    logic        wr_en, wr_val;
    logic [15:0] status_word;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit m_fc, m_rlo, m_sta, m_or, m_grp, m_we, m_wv;

    always #2.5 clk = ~clk;

    bls_top u0 (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .bit_value   (bit_value),
        .wr_en       (wr_en),
        .wr_val      (wr_val),
        .status_word (status_word)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 first-check", 16'(status_word[0]), 16'(m_fc));
        chk("R5/R6 result-of-logic", 16'(status_word[1]), 16'(m_rlo));
        chk("R7 status", 16'(status_word[2]), 16'(m_sta));
        chk("R6 or-pending", 16'(status_word[3]), 16'(m_or));
        chk("R2 upper bits zero", 16'(status_word[15:4]), 16'h0);
        chk("R8/R9/R11 wr_en", 16'(wr_en), 16'(m_we));
        if (m_we) chk("R8/R9 wr_val", 16'(wr_val), 16'(m_wv));
    endtask

    function automatic void model(input bit v, input bit [2:0] op, input bit b);
        bit x;
        m_we = 0;
        if (!v) return;
        if (op < 3'd4) begin
            x = b ^ op[0];
            m_sta = b;
            if (!m_fc) begin
                m_grp = x;
                m_or  = 0;
            end else if (op[1]) begin
                m_or  = m_or | m_grp;
                m_grp = x;
            end else begin
                m_grp = m_grp & x;
            end
            m_rlo = m_or | m_grp;
            m_fc  = 1;
        end else if (op != 3'd7) begin
            case (op)
                3'd4: begin m_we = 1;     m_wv = m_rlo; end
                3'd5: begin m_we = m_rlo; m_wv = 1;     end
                default: begin m_we = m_rlo; m_wv = 0;  end
            endcase
            m_fc = 0;
            m_or = 0;
        end
    endfunction

    // drive at falling edge, let one rising edge pass, compare at next falling edge
    task automatic step(input bit v, input bit [2:0] op, input bit b);
        instr_valid = v;
        instr_op    = op;
        bit_value   = b;
        model(v, op, b);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned lfsr = 32'h1ACE_B00C;
        rst = 1'b1;
        instr_valid = 1'b0;
        instr_op = 3'd0;
        bit_value = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status after reset", status_word, 16'h0);
        chk("R1 wr_en after reset", 16'(wr_en), 16'h0);
        rst = 1'b0;
        m_fc = 0; m_rlo = 0; m_sta = 0; m_or = 0; m_grp = 0; m_we = 0; m_wv = 0;

        // R3: chain start with AND-NOT on a 0 bit loads 1
        step(1, 3'd1, 0);
        chk("R3 negated start rlo", 16'(status_word[1]), 16'h1);
        chk("R7 raw status after AND-NOT", 16'(status_word[2]), 16'h0);
        // R5: AND with 0 drops result
        step(1, 3'd0, 0);
        chk("R5 and-term clears", 16'(status_word[1]), 16'h0);
        // R6: OR 1 opens new group, previous group 0 stored
        step(1, 3'd2, 1);
        chk("R6 or group rlo", 16'(status_word[3:0]), 16'b0111);
        // R6: AND 0 in the second group, OR-pending still 0
        step(1, 3'd0, 0);
        chk("R6 and binds tighter", 16'(status_word[1]), 16'h0);
        // R6: OR-NOT on 0 -> group 1
        step(1, 3'd3, 0);
        chk("R6 orn rlo", 16'(status_word[1]), 16'h1);
        // R6: a finished 1 group kept through AND 0
        step(1, 3'd2, 0);
        step(1, 3'd0, 0);
        chk("R6 held group keeps rlo", 16'(status_word[3:1]), 16'b101);
        // R10: idle cycle and NOP change nothing
        step(0, 3'd4, 1);
        chk("R10 idle no write", 16'(wr_en), 16'h0);
        step(1, 3'd7, 1);
        chk("R10 nop keeps word", 16'(status_word[3:0]), 16'b1011);
        // R8: assign writes 1, chain closes
        step(1, 3'd4, 0);
        chk("R8 assign write", {14'h0, wr_en, wr_val}, 16'h3);
        chk("R4 first-check cleared", 16'(status_word[0]), 16'h0);
        // R11: write pulse lasts one cycle
        step(0, 3'd0, 0);
        chk("R11 single pulse", 16'(wr_en), 16'h0);
        // R9: set with rlo 0 does nothing; reset with rlo 1 writes 0
        step(1, 3'd0, 0);
        step(1, 3'd5, 1);
        chk("R9 set suppressed", 16'(wr_en), 16'h0);
        step(1, 3'd0, 1);
        step(1, 3'd6, 0);
        chk("R9 reset writes 0", {14'h0, wr_en, wr_val}, 16'h2);
        step(1, 3'd2, 1);
        step(1, 3'd5, 0);
        chk("R9 set writes 1", {14'h0, wr_en, wr_val}, 16'h3);

        // R1: reset mid-chain
        step(1, 3'd0, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset mid-chain", status_word, 16'h0);
        rst = 1'b0;
        m_fc = 0; m_rlo = 0; m_sta = 0; m_or = 0; m_grp = 0; m_we = 0;

        // pseudo-random stream, every output compared each cycle
        for (int i = 0; i < 3000; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            step(lfsr[28:26] != 3'd0, lfsr[22:20], lfsr[17]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule